// File: doc/BRIEF.md
# Multiplexed-Address SRAM Bus Emulator

This block stands in for a 2048-byte asynchronous static RAM on the bus of a host CPU. It needs very few pins. The 11-bit address is not wired in parallel. The block drives two active-low select outputs, one at a time, and each select enables a group of external tri-state buffers onto a shared 6-bit address input. The first group carries address bits 0 to 5 and the second carries bits 6 to 10. The block rebuilds the full address from the two partial reads.

The bus has active-low chip-select and write-enable and no output-enable. A write is recognised when write-enable falls during the access. If write-enable is still high after a programmed decision time, the access is treated as a read and the stored byte is driven. Every bus input passes through a two-flop synchronizer. All timing thresholds are counts of system-clock cycles.

A maintenance port can load bytes, clear a whole bank, or rotate which bank the host sees. These operations run only while the wait output stalls the host.

Top module: `mux_sram_emu`

## Requirements
- R1: After reset both select outputs are high, the data driver is off (`data_oe_o` = 0), `wait_no` is high and bank 0 is the bank the host sees.
- R2: After a synchronized chip-select fall, `sel_lo_no` is low for SEL_CYC cycles and then `sel_hi_no` is low for SEL_CYC cycles. The two selects are never low together. Address bits 0..5 come from `addr_part_i[5:0]` in the first phase and bits 6..10 from `addr_part_i[4:0]` in the second.
- R3: On a write, `data_i` is captured WR_CYC cycles after the synchronized write-enable fall and stored at the rebuilt address in the host's bank.
- R4: If write-enable is still high RD_CYC cycles after the chip-select fall, the byte at the rebuilt address is placed on `data_o` and `data_oe_o` is set. The driver turns on only in a cycle after write-enable was seen high, and it turns off one clock after the synchronized chip-select rise.
- R5: `wait_no` is low whenever `mnt_req_i` is high or a clear sweep is running.
- R6: A maintenance write (`mnt_we_i`) is applied only while wait is asserted and no host access is in progress. Otherwise it has no effect on memory, and it never shares a cycle with a host write.
- R7: A one-cycle `mnt_clr_i` pulse, when accepted, writes zero to all 2048 bytes of bank `mnt_bank_i`. `wait_no` stays low for the whole sweep, about 2048 cycles, even if `mnt_req_i` drops.
- R8: An accepted `mnt_swap_i` pulse advances the host bank to the next one, wrapping to bank 0. Each bank keeps its own contents.
- R9: An access ends on either rising edge. If write-enable rises before the sample point, the write is committed at that moment. A new access needs a new chip-select fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Host chip-select, active low |
| we_ni | input | 1 | Host write-enable, active low |
| sel_lo_no | output | 1 | Enables the buffers carrying address bits 0..5, active low |
| sel_hi_no | output | 1 | Enables the buffers carrying address bits 6..10, active low |
| addr_part_i | input | LO_W | Shared partial address from the external buffers |
| data_i | input | DATA_W | Data bus input |
| data_o | output | DATA_W | Read data toward the bus |
| data_oe_o | output | 1 | Data bus driver enable |
| wait_no | output | 1 | Host wait request, active low |
| mnt_req_i | input | 1 | Maintenance requests a host stall |
| mnt_we_i | input | 1 | Maintenance write strobe |
| mnt_addr_i | input | ADDR_W | Maintenance address |
| mnt_data_i | input | DATA_W | Maintenance write data |
| mnt_bank_i | input | BW | Bank targeted by a maintenance write or clear |
| mnt_clr_i | input | 1 | Start a clear sweep of `mnt_bank_i` |
| mnt_swap_i | input | 1 | Advance the bank the host sees |

## Verification
A maintenance write strobe and the start of a host access can land in the same clock cycle. In that cycle the maintenance port must lose: the write is dropped and the host access goes ahead. The bench provokes this by raising the stall request and then letting the host start a write anyway, with the maintenance strobe pulsed to a neighbouring address just after chip-select has passed the synchronizer. It judges the outcome by two host read-backs: the neighbouring address must still hold its old byte, and the host's address must hold the host's data.

// File: rtl/mse_pkg.sv
package mse_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LO,
    ST_HI,
    ST_ARM,
    ST_WR,
    ST_END,
    ST_RD
  } host_st_e;
endpackage

// File: rtl/mse_sync.sv
module mse_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/mse_mem.sv
module mse_mem #(
  parameter int AW    = 11,
  parameter int DW    = 8,
  parameter int BANKS = 2,
  parameter int BW    = 1
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [BW-1:0] wbank_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [BW-1:0] rbank_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] rd_b [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DW-1:0] arr [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && wbank_i == BW'(b)) arr[waddr_i] <= wdata_i;
    end
    assign rd_b[b] = arr[raddr_i];
  end

  assign rdata_o = rd_b[rbank_i];
endmodule

// File: rtl/mse_host_fsm.sv
module mse_host_fsm
  import mse_pkg::*;
#(
  parameter int AW      = 11,
  parameter int DW      = 8,
  parameter int LO_W    = 6,
  parameter int SEL_CYC = 6,
  parameter int WR_CYC  = 36,
  parameter int RD_CYC  = 110
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_si,
  input  logic            we_si,
  input  logic [LO_W-1:0] part_si,
  input  logic [DW-1:0]   data_si,
  input  logic [DW-1:0]   rd_data_i,
  output logic            sel_lo_no,
  output logic            sel_hi_no,
  output logic [AW-1:0]   addr_o,
  output logic            wr_o,
  output logic [DW-1:0]   wr_data_o,
  output logic            oe_o,
  output logic [DW-1:0]   rd_q_o,
  output logic            idle_o
);
  localparam int HI_W = AW - LO_W;
  localparam int PMAX = (SEL_CYC > WR_CYC) ? SEL_CYC : WR_CYC;
  localparam int CW   = $clog2(PMAX + 1);
  localparam int TW   = $clog2(RD_CYC + 1);
  localparam logic [CW-1:0] SEL_LAST = CW'(SEL_CYC - 1);
  localparam logic [CW-1:0] WR_LAST  = CW'(WR_CYC - 1);
  localparam logic [TW-1:0] RD_T     = TW'(RD_CYC);

  host_st_e      st;
  logic [CW-1:0] cnt;
  logic [TW-1:0] acc;
  logic          cs_prev;
  logic          cs_fall;

  assign cs_fall   = cs_prev & ~cs_si;
  assign sel_lo_no = ~(st == ST_LO);
  assign sel_hi_no = ~(st == ST_HI);
  assign idle_o    = (st == ST_IDLE) & cs_si;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      acc       <= '0;
      cs_prev   <= 1'b1;
      addr_o    <= '0;
      wr_o      <= 1'b0;
      wr_data_o <= '0;
      oe_o      <= 1'b0;
      rd_q_o    <= '0;
    end else begin
      cs_prev <= cs_si;
      wr_o    <= 1'b0;
      oe_o    <= 1'b0;
      if (st != ST_IDLE && acc != RD_T) acc <= acc + 1'b1;
      unique case (st)
        ST_IDLE: begin
          if (cs_fall) begin
            st  <= ST_LO;
            cnt <= '0;
            acc <= '0;
          end
        end
        ST_LO: begin
          if (cs_si) st <= ST_IDLE;
          else if (cnt == SEL_LAST) begin
            addr_o[LO_W-1:0] <= part_si;
            cnt <= '0;
            st  <= ST_HI;
          end else cnt <= cnt + 1'b1;
        end
        ST_HI: begin
          if (cs_si) st <= ST_IDLE;
          else if (cnt == SEL_LAST) begin
            addr_o[AW-1:LO_W] <= part_si[HI_W-1:0];
            cnt <= '0;
            st  <= ST_ARM;
          end else cnt <= cnt + 1'b1;
        end
        ST_ARM: begin
          if (cs_si) st <= ST_IDLE;
          else if (!we_si) begin
            st  <= ST_WR;
            cnt <= '0;
          end else if (acc == RD_T) begin
            st     <= ST_RD;
            rd_q_o <= rd_data_i;
            oe_o   <= 1'b1;
          end
        end
        ST_WR: begin
          // commit at the sample point, or early if the access ends first
          if (cs_si || we_si || cnt == WR_LAST) begin
            wr_o      <= 1'b1;
            wr_data_o <= data_si;
            st        <= cs_si ? ST_IDLE : ST_END;
          end else cnt <= cnt + 1'b1;
        end
        ST_END: begin
          if (cs_si) st <= ST_IDLE;
        end
        ST_RD: begin
          if (cs_si) st <= ST_IDLE;
          else if (!we_si) begin
            st  <= ST_WR;
            cnt <= '0;
          end else oe_o <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mse_maint.sv
module mse_maint #(
  parameter int AW    = 11,
  parameter int DW    = 8,
  parameter int BANKS = 2,
  parameter int BW    = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [BW-1:0] bank_i,
  input  logic          clr_i,
  input  logic          swap_i,
  input  logic          host_idle_i,
  output logic          wait_no,
  output logic          mw_o,
  output logic [AW-1:0] maddr_o,
  output logic [DW-1:0] mdata_o,
  output logic [BW-1:0] mbank_o,
  output logic [BW-1:0] act_bank_o
);
  logic          busy;
  logic [AW-1:0] clr_addr;
  logic [BW-1:0] clr_bank;
  logic          ok;

  assign wait_no = ~(req_i | busy);
  assign ok      = req_i & ~busy & host_idle_i;
  assign mw_o    = busy ? host_idle_i : (we_i & ok);
  assign maddr_o = busy ? clr_addr : addr_i;
  assign mdata_o = busy ? '0 : data_i;
  assign mbank_o = busy ? clr_bank : bank_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy       <= 1'b0;
      clr_addr   <= '0;
      clr_bank   <= '0;
      act_bank_o <= '0;
    end else begin
      if (busy) begin
        if (host_idle_i) begin
          clr_addr <= clr_addr + 1'b1;
          if (clr_addr == '1) busy <= 1'b0;
        end
      end else if (clr_i && ok) begin
        busy     <= 1'b1;
        clr_addr <= '0;
        clr_bank <= bank_i;
      end
      if (swap_i && ok)
        act_bank_o <= (act_bank_o == BW'(BANKS - 1)) ? '0 : act_bank_o + 1'b1;
    end
  end
endmodule

// File: rtl/mux_sram_emu.sv
module mux_sram_emu #(
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 8,
  parameter int LO_W    = 6,
  parameter int BANKS   = 2,
  parameter int SEL_CYC = 6,
  parameter int WR_CYC  = 36,
  parameter int RD_CYC  = 110,
  localparam int BW     = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              we_ni,
  output logic              sel_lo_no,
  output logic              sel_hi_no,
  input  logic [LO_W-1:0]   addr_part_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              wait_no,
  input  logic              mnt_req_i,
  input  logic              mnt_we_i,
  input  logic [ADDR_W-1:0] mnt_addr_i,
  input  logic [DATA_W-1:0] mnt_data_i,
  input  logic [BW-1:0]     mnt_bank_i,
  input  logic              mnt_clr_i,
  input  logic              mnt_swap_i
);
  logic              cs_s, we_s;
  logic [LO_W-1:0]   part_s;
  logic [DATA_W-1:0] data_s;
  logic [ADDR_W-1:0] host_addr, mnt_addr;
  logic [DATA_W-1:0] host_wdata, mnt_wdata, rd_data;
  logic              host_wr, mnt_wr, host_idle;
  logic [BW-1:0]     act_bank, mnt_bank;
  logic              mem_we;
  logic [BW-1:0]     mem_bank;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;

  mse_sync #(.W(2), .RST_VAL(2'b11)) u_sync_ctl (
    .clk_i, .rst_ni, .d_i({cs_ni, we_ni}), .q_o({cs_s, we_s})
  );
  mse_sync #(.W(LO_W)) u_sync_addr (
    .clk_i, .rst_ni, .d_i(addr_part_i), .q_o(part_s)
  );
  mse_sync #(.W(DATA_W)) u_sync_data (
    .clk_i, .rst_ni, .d_i(data_i), .q_o(data_s)
  );

  mse_host_fsm #(
    .AW(ADDR_W), .DW(DATA_W), .LO_W(LO_W),
    .SEL_CYC(SEL_CYC), .WR_CYC(WR_CYC), .RD_CYC(RD_CYC)
  ) u_host (
    .clk_i, .rst_ni,
    .cs_si(cs_s), .we_si(we_s), .part_si(part_s), .data_si(data_s),
    .rd_data_i(rd_data),
    .sel_lo_no, .sel_hi_no,
    .addr_o(host_addr), .wr_o(host_wr), .wr_data_o(host_wdata),
    .oe_o(data_oe_o), .rd_q_o(data_o), .idle_o(host_idle)
  );

  mse_maint #(.AW(ADDR_W), .DW(DATA_W), .BANKS(BANKS), .BW(BW)) u_maint (
    .clk_i, .rst_ni,
    .req_i(mnt_req_i), .we_i(mnt_we_i), .addr_i(mnt_addr_i), .data_i(mnt_data_i),
    .bank_i(mnt_bank_i), .clr_i(mnt_clr_i), .swap_i(mnt_swap_i),
    .host_idle_i(host_idle),
    .wait_no, .mw_o(mnt_wr), .maddr_o(mnt_addr), .mdata_o(mnt_wdata),
    .mbank_o(mnt_bank), .act_bank_o(act_bank)
  );

  assign mem_we    = host_wr | mnt_wr;
  assign mem_bank  = host_wr ? act_bank   : mnt_bank;
  assign mem_addr  = host_wr ? host_addr  : mnt_addr;
  assign mem_wdata = host_wr ? host_wdata : mnt_wdata;

  mse_mem #(.AW(ADDR_W), .DW(DATA_W), .BANKS(BANKS), .BW(BW)) u_mem (
    .clk_i,
    .we_i(mem_we), .wbank_i(mem_bank), .waddr_i(mem_addr), .wdata_i(mem_wdata),
    .rbank_i(act_bank), .raddr_i(host_addr), .rdata_o(rd_data)
  );
endmodule

// File: rtl/mse_chk.sv
module mse_chk #(
  parameter int AW = 11,
  parameter int BW = 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sel_lo_no,
  input logic          sel_hi_no,
  input logic          data_oe_o,
  input logic          wait_no,
  input logic          cs_s,
  input logic          we_s,
  input logic          host_wr,
  input logic          mnt_wr,
  input logic [AW-1:0] host_addr,
  input logic [BW-1:0] act_bank
);
  // R2
  sel_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sel_lo_no && !sel_hi_no));
  // R2
  sel_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sel_hi_no) |-> $past(!sel_lo_no));
  // R4
  oe_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> $past(we_s));
  // R4
  oe_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_s) |=> !data_oe_o);
  // R3
  wr_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr |-> $stable(host_addr));
  // R6
  wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_wr && mnt_wr));
  // R5
  mnt_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mnt_wr |-> !wait_no);
  // R8
  bank_chg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_bank) |-> $past(!wait_no));
endmodule

bind mux_sram_emu mse_chk #(.AW(ADDR_W), .BW(BW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_lo_no(sel_lo_no), .sel_hi_no(sel_hi_no),
  .data_oe_o(data_oe_o), .wait_no(wait_no), .cs_s(cs_s), .we_s(we_s),
  .host_wr(host_wr), .mnt_wr(mnt_wr), .host_addr(host_addr), .act_bank(act_bank)
);

// File: tb/mux_sram_emu_test.sv
module mux_sram_emu_test;
  // time unit scaled so that NS units equal 1 ns; 200 MHz clock
  localparam int NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, we_n = 1'b1;
  logic [10:0] cur_addr = '0;
  logic [7:0]  dbus = '0;
  logic        sel_lo_n, sel_hi_n;
  logic [5:0]  part;
  logic [7:0]  dout;
  logic        oe, wait_n;
  logic        m_req = 0, m_we = 0, m_clr = 0, m_swap = 0;
  logic [10:0] m_addr = '0;
  logic [7:0]  m_data = '0;
  logic        m_bank = 0;
  int checks = 0, fails = 0;
  int sel_bad = 0, oe_bad = 0, we_low = 0, cs_high = 0;
  logic [7:0] mdl [2][2048];

  always #(25) clk = ~clk;

  // external buffer groups sharing the partial-address pins
  assign part = !sel_lo_n ? cur_addr[5:0] : !sel_hi_n ? {1'b0, cur_addr[10:6]} : 6'h3f;

  mux_sram_emu uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .we_ni(we_n),
    .sel_lo_no(sel_lo_n), .sel_hi_no(sel_hi_n), .addr_part_i(part),
    .data_i(dbus), .data_o(dout), .data_oe_o(oe), .wait_no(wait_n),
    .mnt_req_i(m_req), .mnt_we_i(m_we), .mnt_addr_i(m_addr), .mnt_data_i(m_data),
    .mnt_bank_i(m_bank), .mnt_clr_i(m_clr), .mnt_swap_i(m_swap)
  );

  always @(negedge clk) if (rst_n) begin
    if (!sel_lo_n && !sel_hi_n) sel_bad++;
    we_low  = we_n ? 0 : we_low + 1;
    cs_high = cs_n ? cs_high + 1 : 0;
    if (oe && (we_low > 4 || cs_high > 4)) oe_bad++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [10:0] a, input logic [7:0] d, input int we_len, input int gap);
    @(negedge clk);
    cur_addr = a;
    #(320*NS) cs_n = 0;
    #(480*NS) we_n = 0;
    #(60*NS)  dbus = d;
    #((we_len-60)*NS) we_n = 1;
    #(gap*NS) cs_n = 1;
    #(40*NS)  dbus = 8'h00;
    #(200*NS);
  endtask

  task automatic hr(input logic [10:0] a, output logic [7:0] d, output logic drv);
    @(negedge clk);
    cur_addr = a;
    #(320*NS) cs_n = 0;
    #(1000*NS) d = dout; drv = oe;
    #(120*NS) cs_n = 1;
    #(30*NS) chk("R4 driver off after cs rise", oe, 1'b0);
    #(200*NS);
  endtask

  task automatic rd_chk(input string tag, input logic [10:0] a, input logic [7:0] exp);
    logic [7:0] d; logic drv;
    hr(a, d, drv);
    chk(tag, d, exp);
    chk("R4 driver on during read", drv, 1'b1);
  endtask

  task automatic mw(input logic bank, input logic [10:0] a, input logic [7:0] d, input logic req);
    @(negedge clk);
    m_req = req; m_bank = bank; m_addr = a; m_data = d; m_we = 1;
    @(negedge clk);
    m_we = 0; m_req = 0;
    @(negedge clk);
  endtask

  task automatic swap();
    @(negedge clk); m_req = 1; m_swap = 1;
    @(negedge clk); m_swap = 0; m_req = 0;
    @(negedge clk);
  endtask

  // {write, addr, data}; reads expect data
  localparam logic [19:0] VEC [16] = '{
    {1'b1, 11'h000, 8'h5a}, {1'b1, 11'h7ff, 8'ha5}, {1'b1, 11'h03f, 8'h3c},
    {1'b1, 11'h040, 8'hc3}, {1'b1, 11'h7c0, 8'h81}, {1'b1, 11'h555, 8'h55},
    {1'b1, 11'h2aa, 8'haa}, {1'b0, 11'h000, 8'h5a}, {1'b0, 11'h7ff, 8'ha5},
    {1'b0, 11'h03f, 8'h3c}, {1'b0, 11'h040, 8'hc3}, {1'b0, 11'h7c0, 8'h81},
    {1'b0, 11'h555, 8'h55}, {1'b0, 11'h2aa, 8'haa}, {1'b1, 11'h040, 8'h11},
    {1'b0, 11'h040, 8'h11}
  };

  initial begin
    #(7_500_000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [10:0] ra [24];
    int cnt;
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    chk("R1 sel_lo in reset", sel_lo_n, 1'b1);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 sel_lo idle", sel_lo_n, 1'b1);
    chk("R1 sel_hi idle", sel_hi_n, 1'b1);
    chk("R1 driver off", oe, 1'b0);
    chk("R1 wait released", wait_n, 1'b1);

    // R2 R3 R4 table walk
    for (int i = 0; i < 16; i++) begin
      if (VEC[i][19]) hw(VEC[i][18:8], VEC[i][7:0], 600, 40);
      else rd_chk("R2 R3 table readback", VEC[i][18:8], VEC[i][7:0]);
    end

    // R6 maintenance write without wait is ignored
    mw(1'b0, 11'h000, 8'hee, 1'b0);
    rd_chk("R6 write without wait ignored", 11'h000, 8'h5a);

    // R5 wait follows request; maintenance writes land
    @(negedge clk); m_req = 1;
    @(negedge clk); chk("R5 wait asserted", wait_n, 1'b0);
    mw(1'b0, 11'h000, 8'h11, 1'b1);
    mw(1'b1, 11'h000, 8'h77, 1'b1);
    chk("R5 wait released", wait_n, 1'b1);
    rd_chk("R6 maintenance write bank 0", 11'h000, 8'h11);

    // R8 bank rotate
    swap();
    rd_chk("R8 bank 1 served", 11'h000, 8'h77);
    swap();
    rd_chk("R8 bank 0 back", 11'h000, 8'h11);
    rd_chk("R8 bank 0 intact", 11'h7ff, 8'ha5);

    // R7 clear sweep of bank 1
    @(negedge clk); m_req = 1; m_bank = 1; m_clr = 1;
    @(negedge clk); m_clr = 0; m_req = 0;
    @(negedge clk); chk("R7 wait held during sweep", wait_n, 1'b0);
    cnt = 0;
    while (!wait_n && cnt < 5000) begin @(negedge clk); cnt++; end
    chk("R7 sweep length", (cnt >= 2040 && cnt <= 2050), 1'b1);
    swap();
    rd_chk("R7 cleared low", 11'h000, 8'h00);
    rd_chk("R7 cleared high", 11'h7ff, 8'h00);
    swap();
    rd_chk("R7 other bank untouched", 11'h000, 8'h11);

    // R9 early write-enable rise and simultaneous rise
    hw(11'h321, 8'h6b, 100, 40);
    rd_chk("R9 early we rise commits", 11'h321, 8'h6b);
    hw(11'h322, 8'hd4, 600, 0);
    rd_chk("R9 simultaneous rise", 11'h322, 8'hd4);

    // R6 collision: maintenance strobe during a host access start
    hw(11'h124, 8'h0f, 600, 40);
    m_req = 1;
    fork
      hw(11'h123, 8'h3c, 600, 40);
      begin
        wait (!cs_n);
        #(20*NS) m_addr = 11'h124; m_data = 8'h99; m_bank = 0; m_we = 1;
        #(5*NS*NS/10) m_we = 0;
      end
    join
    m_req = 0;
    rd_chk("R6 colliding maintenance write dropped", 11'h124, 8'h0f);
    rd_chk("R3 host write during collision", 11'h123, 8'h3c);

    // random read-after-write across both banks
    for (int i = 0; i < 24; i++) begin
      logic [7:0] d;
      if (i == 12) swap();
      ra[i] = 11'($urandom % 2048);
      d = 8'($urandom);
      mdl[(i >= 12) ? 1 : 0][ra[i]] = d;
      hw(ra[i], d, 600, 40);
    end
    for (int i = 12; i < 24; i++) rd_chk("R3 R8 random bank 1", ra[i], mdl[1][ra[i]]);
    swap();
    for (int i = 0; i < 12; i++) rd_chk("R3 R8 random bank 0", ra[i], mdl[0][ra[i]]);

    chk("R2 selects never both low", sel_bad, 0);
    chk("R4 driver off while we low or cs high", oe_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule